// File: doc/BRIEF.md
# Column-Compressed Eight-Operand Adder

This block is a purely combinational adder. It sums eight unsigned 5-bit operands into one 8-bit result. The operands are laid out as a bit matrix, one column per binary weight. The matrix is then compressed one column at a time by full adders, used as 3:2 counters, and half adders, used as 2:2 counters. The compression runs over a fixed sequence of levels. Each level brings every column down to a set maximum height, and a ripple carry-propagate adder merges the two rows that remain.

The number of counters in each column is fixed when the design is elaborated. It comes from the height each column must reach and from the carries arriving from the column below, and the rule is chosen so that the fewest carries are produced. For the default sizes this places 26 full adders and 4 half adders. The block has no clock and no storage. The result follows the operands through the combinational path. Because the block holds no state, it has no stream handshake. A caller that needs one registers the operands or the result around the block.

Top module: `colred_sum`

## Requirements
- R1: `sum` equals the unsigned arithmetic sum of the eight operands, as an 8-bit value. It changes combinationally with `ops` and needs no clock edge.
- R2: When every operand is zero, `sum` is 0.
- R3: When every operand is 31, `sum` is 248. No carry ever leaves the most significant column or the final adder, so no sum wraps.
- R4: The compression uses four levels with maximum column heights 6, 4, 3 and 2, in that order. After each level, no column holds more bits than that level's height. The final adder receives at most two bits per column.
- R5: In each column, a level places floor(p/2) full adders and (p mod 2) half adders, where p = height − target + carries arriving from the column below, with p clamped at 0. Every counter keeps the number of ones it consumes, counting a carry as two, and every level keeps the weighted value of the matrix.
- R6: Each operand contributes with weight one whatever its position. An operand `ops[k]`, with slot k at bits 5k+4..5k, set alone gives `sum` equal to its value.
- R7: When one bit weight 2^j is set in all eight operands and every other bit is clear, the result is 8·2^j. This is the case of a single full column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ops | input | 40 | Eight packed 5-bit unsigned operands; operand k occupies bits 5k+4..5k |
| sum | output | 8 | Unsigned sum of the eight operands |

## Verification
The assertions are immediate and are evaluated each time their inputs change. They check the following:
- at every level, each column stays within its input and output height bound;
- every counter keeps the number of ones it consumes;
- every level keeps the weighted value of the matrix;
- no carry leaves the top column or the final adder;
- `sum` matches a reference sum computed beside the design.

The bench scenarios cover the behaviour that is shown by chosen operand patterns:
- all-zero operands;
- all-ones operands;
- a single operand set alone in each slot;
- a single full column at each weight;
- patterns just under the maximum;
- a sweep of random vectors whose expected sums are computed in the bench.

// File: rtl/colred_pkg.sv
package colred_pkg;
  localparam int N_OPS = 8;
  localparam int OP_W  = 5;
  localparam int SUM_W = $clog2(N_OPS * ((1 << OP_W) - 1) + 1);
  localparam int COLS  = SUM_W;
  localparam int MAXH  = N_OPS;

  typedef logic [MAXH-1:0] col_t;
  typedef col_t [COLS-1:0] mat_t;

  // Height limit series 2, 3, 4, 6, 9, ... (each term is 3/2 of the last, floored)
  function automatic int height_series(int j);
    int d;
    d = 2;
    for (int k = 1; k < j; k++) d = (d * 3) / 2;
    return d;
  endfunction

  function automatic int count_levels();
    int n;
    n = 0;
    for (int j = 1; j < 32; j++)
      if (height_series(j) < N_OPS) n = j;
    return n;
  endfunction

  localparam int LEVELS = count_levels();

  // Target column height after level lvl (lvl 0 is the first level)
  function automatic int level_target(int lvl);
    return height_series(LEVELS - lvl);
  endfunction

  // Elaboration-time plan: sel 0 = input height, 1 = full adders,
  // 2 = half adders, 3 = carries arriving from column col-1
  function automatic int level_plan(int lvl, int col, int sel);
    int e  [COLS];
    int ne [COLS];
    int f, h, cin, p, res;
    res = 0;
    for (int c = 0; c < COLS; c++) e[c] = (c < OP_W) ? N_OPS : 0;
    for (int l = 0; l <= lvl; l++) begin
      cin = 0;
      for (int c = 0; c < COLS; c++) begin
        p = e[c] - level_target(l) + cin;
        if (p < 0) p = 0;
        f = p / 2;
        h = p % 2;
        if (l == lvl && c == col) begin
          case (sel)
            0:       res = e[c];
            1:       res = f;
            2:       res = h;
            default: res = cin;
          endcase
        end
        ne[c] = e[c] - 2 * f - h + cin;
        cin   = f + h;
      end
      for (int c = 0; c < COLS; c++) e[c] = ne[c];
    end
    return res;
  endfunction

  function automatic int mat_value(mat_t m);
    int v;
    v = 0;
    for (int c = 0; c < COLS; c++) v += $countones(m[c]) << c;
    return v;
  endfunction
endpackage

// File: rtl/colred_fa.sv
module colred_fa (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ c;
  assign co = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/colred_ha.sv
module colred_ha (
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  assign s  = a ^ b;
  assign co = a & b;
endmodule

// File: rtl/colred_level.sv
module colred_level
  import colred_pkg::*;
#(
  parameter int LVL = 0
) (
  input  mat_t in_m,
  output mat_t out_m
);
  localparam int TGT = level_target(LVL);

  mat_t sum_w;
  mat_t cy_w;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int E    = level_plan(LVL, c, 0);
    localparam int F    = level_plan(LVL, c, 1);
    localparam int H    = level_plan(LVL, c, 2);
    localparam int CIN  = level_plan(LVL, c, 3);
    localparam int USED = 3 * F + 2 * H;
    localparam int PASS = E - USED;
    localparam int CB   = (c == 0) ? 0 : c - 1;
    localparam col_t USED_MASK = col_t'((1 << USED) - 1);

    // Counters: rows 0..F-1 full adders, rows F..F+H-1 half adders
    for (genvar r = 0; r < MAXH; r++) begin : g_cell
      if (r < F) begin : g_fa
        colred_fa u_fa (
          .a (in_m[c][3*r]),
          .b (in_m[c][3*r+1]),
          .c (in_m[c][3*r+2]),
          .s (sum_w[c][r]),
          .co(cy_w[c][r])
        );
      end else if (r < F + H) begin : g_ha
        colred_ha u_ha (
          .a (in_m[c][3*F + 2*(r-F)]),
          .b (in_m[c][3*F + 2*(r-F) + 1]),
          .s (sum_w[c][r]),
          .co(cy_w[c][r])
        );
      end else begin : g_none
        assign sum_w[c][r] = 1'b0;
        assign cy_w[c][r]  = 1'b0;
      end
    end

    // Output column: untouched bits, then sums, then carries from below
    for (genvar r = 0; r < MAXH; r++) begin : g_out
      if (r < PASS) begin : g_pass
        assign out_m[c][r] = in_m[c][USED + r];
      end else if (r < PASS + F + H) begin : g_sum
        assign out_m[c][r] = sum_w[c][r - PASS];
      end else if (r < PASS + F + H + CIN) begin : g_cy
        assign out_m[c][r] = cy_w[CB][r - PASS - F - H];
      end else begin : g_zero
        assign out_m[c][r] = 1'b0;
      end
    end

    always_comb begin
      if (!$isunknown(in_m) && !$isunknown(out_m)) begin
        // R4: incoming column respects the height planned for this level
        assert_in_height_R4: assert ((in_m[c] >> E) == '0)
          else $error("column %0d exceeds input height %0d", c, E);
        // R4: outgoing column within the level target
        assert_out_height_R4: assert ((out_m[c] >> TGT) == '0)
          else $error("column %0d exceeds target %0d", c, TGT);
        // R5: counters conserve the ones they consume
        assert_counter_conserve_R5: assert (
          $countones(sum_w[c]) + 2 * $countones(cy_w[c]) ==
          $countones(in_m[c] & USED_MASK))
          else $error("column %0d counters lose ones", c);
      end
    end
  end

  always_comb begin
    if (!$isunknown(in_m) && !$isunknown(out_m)) begin
      // R3: nothing carried out of the most significant column
      assert_no_top_carry_R3: assert (cy_w[COLS-1] == '0)
        else $error("carry leaves top column at level %0d", LVL);
      // R5: the level preserves the weighted matrix value
      assert_value_kept_R5: assert (mat_value(in_m) == mat_value(out_m))
        else $error("level %0d changes matrix value", LVL);
    end
  end
endmodule

// File: rtl/colred_cpa.sv
module colred_cpa
  import colred_pkg::*;
(
  input  mat_t                   fin_m,
  output logic [SUM_W-1:0]       s
);
  logic [SUM_W:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < SUM_W; i++) begin : g_bit
    colred_fa u_fa (
      .a (fin_m[i][0]),
      .b (fin_m[i][1]),
      .c (cy[i]),
      .s (s[i]),
      .co(cy[i+1])
    );
  end

  always_comb begin
    if (!$isunknown(fin_m) && !$isunknown(cy)) begin
      // R4: only two rows reach the carry-propagate adder
      for (int c = 0; c < COLS; c++)
        assert_two_rows_R4: assert ((fin_m[c] >> 2) == '0)
          else $error("column %0d has more than two rows at the adder", c);
      // R3: final adder never overflows
      assert_no_overflow_R3: assert (cy[SUM_W] == 1'b0)
        else $error("final adder carry out");
    end
  end
endmodule

// File: rtl/colred_sum.sv
module colred_sum
  import colred_pkg::*;
(
  input  logic [N_OPS-1:0][OP_W-1:0] ops,
  output logic [SUM_W-1:0]           sum
);
  mat_t stage [LEVELS+1];

  // Initial matrix: column c, row r holds bit c of operand r
  for (genvar c = 0; c < COLS; c++) begin : g_init_col
    for (genvar r = 0; r < MAXH; r++) begin : g_init_row
      if (c < OP_W && r < N_OPS) begin : g_bit
        assign stage[0][c][r] = ops[r][c];
      end else begin : g_zero
        assign stage[0][c][r] = 1'b0;
      end
    end
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    colred_level #(.LVL(l)) u_level (
      .in_m (stage[l]),
      .out_m(stage[l+1])
    );
  end

  colred_cpa u_cpa (
    .fin_m(stage[LEVELS]),
    .s    (sum)
  );

  int ref_sum;
  always_comb begin
    ref_sum = 0;
    for (int k = 0; k < N_OPS; k++) ref_sum += int'(ops[k]);
  end

  always_comb begin
    if (!$isunknown(ops) && !$isunknown(sum)) begin
      // R1: result equals arithmetic sum of operands
      assert_sum_match_R1: assert (int'(sum) == ref_sum)
        else $error("sum %0d differs from %0d", sum, ref_sum);
    end
  end
endmodule

// File: tb/tb_colred_sum.sv
module tb_colred_sum;
  import colred_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic [N_OPS-1:0][OP_W-1:0] ops;
  logic [SUM_W-1:0] sum;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  colred_sum dut (.ops(ops), .sum(sum));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bench_sum(logic [N_OPS-1:0][OP_W-1:0] v);
    int a;
    a = 0;
    for (int k = 0; k < N_OPS; k++) a += int'(v[k]);
    return a;
  endfunction

  // Drive after a rising edge, sample at the following falling edge
  task automatic apply(input logic [N_OPS-1:0][OP_W-1:0] v);
    @(posedge clk);
    ops = v;
    @(negedge clk);
  endtask

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(sum) !== exp) begin
      errors++;
      $display("FAIL %s: sum=%0d expected=%0d", req, sum, exp);
    end
  endtask

  task automatic t_zero();
    apply('0);
    check("R2 all zero", 0);
  endtask

  task automatic t_all_ones();
    logic [N_OPS-1:0][OP_W-1:0] v;
    for (int k = 0; k < N_OPS; k++) v[k] = OP_W'((1 << OP_W) - 1);
    apply(v);
    check("R3 all ones", 248);
    v[3] = '0;
    apply(v);
    check("R3 seven max one zero", 217);
  endtask

  task automatic t_single_operand();
    int vals [3] = '{1, 31, 17};
    for (int k = 0; k < N_OPS; k++) begin
      for (int i = 0; i < 3; i++) begin
        logic [N_OPS-1:0][OP_W-1:0] v;
        v = '0;
        v[k] = OP_W'(vals[i]);
        apply(v);
        check("R6 single operand", vals[i]);
      end
    end
  endtask

  task automatic t_full_column();
    for (int j = 0; j < OP_W; j++) begin
      logic [N_OPS-1:0][OP_W-1:0] v;
      for (int k = 0; k < N_OPS; k++) v[k] = OP_W'(1 << j);
      apply(v);
      check("R7 full column (R4 heights)", 8 << j);
    end
  endtask

  task automatic t_alternating();
    logic [N_OPS-1:0][OP_W-1:0] v;
    for (int k = 0; k < N_OPS; k++) v[k] = (k % 2 == 0) ? 5'h15 : 5'h0A;
    apply(v);
    check("R5 alternating bits", 124);
    for (int k = 0; k < N_OPS; k++) v[k] = OP_W'(k * 4 + 3);
    apply(v);
    check("R5 ramp", bench_sum(v));
  endtask

  task automatic t_random();
    for (int n = 0; n < 300; n++) begin
      logic [N_OPS-1:0][OP_W-1:0] v;
      for (int k = 0; k < N_OPS; k++) v[k] = OP_W'($urandom);
      apply(v);
      check("R1 random vector", bench_sum(v));
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: sum=%0d expected=completion", sum);
    summary();
  end

  initial begin
    ops = '0;
    repeat (2) @(posedge clk);
    t_zero();
    t_all_ones();
    t_single_operand();
    t_full_column();
    t_alternating();
    t_random();
    t_zero();
    summary();
  end
endmodule